// File: doc/BRIEF.md
# Receive Mailbox Bank Allocator

This block holds a bank of receive mailboxes for a CAN controller. Each frame handed over by the protocol engine carries an identifier, an extended-format flag, a remote-request flag, a length code and eight data bytes. The block stores the frame in the free mailbox with the lowest index. The last mailbox of the bank has a programmable mode. It can be off, or work as an ordinary receive slot, or overwrite its contents when the bank is full. In the overwrite mode it marks that a message was lost. Used this way, the bank acts as a loosely ordered queue. Its overflow shows up on the last slot.

The host sees a bitmap with one ready bit per mailbox and a masked interrupt line. It reads a mailbox through a registered read port that selects the mailbox and the word. It frees mailboxes by writing a bitmask, and every set bit re-arms one slot. When no slot can take a frame, the frame is discarded and a saturating drop counter counts it.

Top module: `rx_mbox_bank`

## Requirements
- R1: While `rst` is high at a clock edge, the ready bitmap, the lost-message flags, `irq`, `drop_count` and `rd_data` are all cleared to zero.
- R2: A frame accepted at a clock edge goes into the lowest-indexed free mailbox, and that mailbox's ready bit reads 1 after the same edge.
- R3: A mailbox whose ready bit is set accepts no new frame until it is re-armed. The next frame goes to the next free index instead. The overwrite case of R5 is the only exception.
- R4: A cycle with `rearm_we` high clears the ready bit of every mailbox whose bit is set in `rearm_mask`. Mailboxes whose mask bit is 0 keep their state.
- R5: When `tail_mode` is 2 (overwrite) and every mailbox is full, a new frame replaces the contents of the last mailbox and sets that mailbox's lost-message flag (status bit 24).
- R6: `tail_mode` 1 makes the last mailbox an ordinary receive slot. Values 0 and 3 switch it off, so it is never filled. A frame that finds no free mailbox, with no overwrite available, is dropped. Dropping leaves every mailbox unchanged and increments `drop_count`, which saturates at all ones.
- R7: Re-arming the last mailbox clears its lost-message flag.
- R8: ID word (`rd_sel` 0). A standard frame stores its 11-bit identifier in bits 28:18 with bit 29 at 0. An extended frame stores its 29-bit identifier in bits 28:0 with bit 29 at 1. Bits 31:30 are zero.
- R9: Status word (`rd_sel` 1). Bits 19:16 hold the length code, bit 20 the remote flag, bit 23 the ready bit and bit 24 the lost flag. All other bits are zero.
- R10: `irq` is high in the cycle after an edge exactly when some mailbox's ready bit and its `irq_en` bit are both 1 after that edge.
- R11: When a frame and a re-arm fall in the same cycle, the allocation sees the ready bits from before the re-arm. The mailbox that receives the frame, including an overwritten last mailbox, ends full, and in the overwrite case also ends with its lost flag set.
- R12: `rd_data` is registered. At each edge it takes the word selected by `rd_mb` and `rd_sel` (2 = data bytes 0..3, 3 = data bytes 4..7, byte 0 in bits 7:0) from the state before that edge. It reads 0 for `rd_mb` of 12 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | A received frame is present this cycle |
| frame_ide | input | 1 | Extended-identifier frame |
| frame_rtr | input | 1 | Remote-request frame |
| frame_id | input | 29 | Identifier (standard uses bits 10:0) |
| frame_dlc | input | 4 | Length code |
| frame_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| tail_mode | input | 2 | Mode of last mailbox: 0 off, 1 receive, 2 overwrite, 3 off |
| rearm_we | input | 1 | Apply re-arm mask this cycle |
| rearm_mask | input | NUM_MB | Mailboxes to free |
| irq_en | input | NUM_MB | Per-mailbox interrupt enable |
| rd_mb | input | IDX_W | Mailbox to read |
| rd_sel | input | 2 | Word select: 0 ID, 1 status, 2 data low, 3 data high |
| rd_data | output | 32 | Registered read word |
| ready_map | output | NUM_MB | Per-mailbox ready bitmap |
| irq | output | 1 | Masked interrupt request |
| drop_count | output | CNT_W | Saturating count of dropped frames |

## Verification
Frame capture and re-arm can fall in the same cycle. In that case the allocation must ignore slots that are being freed right then, and an overwrite of the last slot must win over its own re-arm. The bench provokes this directly: it re-arms a lower slot while a frame arrives, and it re-arms the last slot while an overwrite hits it. Random phases then mix frames and masks at high density. A bench model computes the expected bitmap, read words, lost flag and drop count from the requirements, and every cycle is judged against it.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
  localparam logic [1:0] MODE_OFF = 2'd0;
  localparam logic [1:0] MODE_RX  = 2'd1;
  localparam logic [1:0] MODE_OVR = 2'd2;

  localparam int ST_DLC_LSB = 16;
  localparam int ST_RTR     = 20;
  localparam int ST_RDY     = 23;
  localparam int ST_LOST    = 24;
  localparam int ID_EXT_BIT = 29;
  localparam int STD_SHIFT  = 18;

  typedef enum logic [1:0] {SEL_ID = 2'd0, SEL_STAT = 2'd1, SEL_DLO = 2'd2, SEL_DHI = 2'd3} rd_sel_e;

  typedef struct packed {
    logic       rtr;
    logic [3:0] dlc;
  } meta_t;

  function automatic logic [31:0] pack_id(input logic ide, input logic [28:0] id);
    logic [31:0] w;
    w = '0;
    if (ide) begin
      w[28:0]       = id;
      w[ID_EXT_BIT] = 1'b1;
    end else begin
      w[STD_SHIFT +: 11] = id[10:0];
    end
    return w;
  endfunction
endpackage

// File: rtl/rxmb_pick.sv
module rxmb_pick
  import rxmb_pkg::*;
#(
  parameter int NUM_MB = 12,
  parameter int IDX_W  = $clog2(NUM_MB)
) (
  input  logic [NUM_MB-1:0] full,
  input  logic [1:0]        tail_mode,
  output logic [NUM_MB-1:0] grant,
  output logic [IDX_W-1:0]  idx,
  output logic              any_free,
  output logic              ovr_take
);
  localparam int TAIL = NUM_MB - 1;

  logic [NUM_MB-1:0] free;
  logic              tail_on;
  logic              found;

  assign tail_on = (tail_mode == MODE_RX) || (tail_mode == MODE_OVR);

  always_comb begin
    free       = ~full;
    free[TAIL] = ~full[TAIL] & tail_on;
    grant      = '0;
    idx        = '0;
    found      = 1'b0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (free[i] && !found) begin
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        found    = 1'b1;
      end
    end
    any_free = found;
    ovr_take = !found && (tail_mode == MODE_OVR);
  end
endmodule

// File: rtl/rxmb_store.sv
module rxmb_store
  import rxmb_pkg::*;
#(
  parameter int NUM_MB = 12,
  parameter int IDX_W  = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [31:0]       wid,
  input  meta_t             wmeta,
  input  logic [63:0]       wdata,
  input  logic [NUM_MB-1:0] full,
  input  logic [NUM_MB-1:0] lost,
  input  logic [IDX_W-1:0]  rd_mb,
  input  logic [1:0]        rd_sel,
  output logic [31:0]       rd_data
);
  logic [31:0] id_mem  [NUM_MB];
  meta_t       meta_mem[NUM_MB];
  logic [31:0] dlo_mem [NUM_MB];
  logic [31:0] dhi_mem [NUM_MB];

  always_ff @(posedge clk) begin
    if (we) begin
      id_mem[waddr]   <= wid;
      meta_mem[waddr] <= wmeta;
      dlo_mem[waddr]  <= wdata[31:0];
      dhi_mem[waddr]  <= wdata[63:32];
    end
  end

  logic        mb_ok;
  logic [31:0] stat_w;
  logic [31:0] rd_d;
  meta_t       m;

  assign mb_ok = (int'(rd_mb) < NUM_MB);

  always_comb begin
    m      = mb_ok ? meta_mem[rd_mb] : '0;
    stat_w = '0;
    stat_w[ST_DLC_LSB +: 4] = m.dlc;
    stat_w[ST_RTR]          = m.rtr;
    stat_w[ST_RDY]          = mb_ok ? full[rd_mb] : 1'b0;
    stat_w[ST_LOST]         = mb_ok ? lost[rd_mb] : 1'b0;
    rd_d = '0;
    if (mb_ok) begin
      unique case (rd_sel_e'(rd_sel))
        SEL_ID:   rd_d = id_mem[rd_mb];
        SEL_STAT: rd_d = stat_w;
        SEL_DLO:  rd_d = dlo_mem[rd_mb];
        SEL_DHI:  rd_d = dhi_mem[rd_mb];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_d;
  end
endmodule

// File: rtl/rx_mbox_bank.sv
module rx_mbox_bank
  import rxmb_pkg::*;
#(
  parameter int NUM_MB = 12,
  parameter int CNT_W  = 8,
  parameter int IDX_W  = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_valid,
  input  logic              frame_ide,
  input  logic              frame_rtr,
  input  logic [28:0]       frame_id,
  input  logic [3:0]        frame_dlc,
  input  logic [63:0]       frame_data,
  input  logic [1:0]        tail_mode,
  input  logic              rearm_we,
  input  logic [NUM_MB-1:0] rearm_mask,
  input  logic [NUM_MB-1:0] irq_en,
  input  logic [IDX_W-1:0]  rd_mb,
  input  logic [1:0]        rd_sel,
  output logic [31:0]       rd_data,
  output logic [NUM_MB-1:0] ready_map,
  output logic              irq,
  output logic [CNT_W-1:0]  drop_count
);
  localparam int TAIL = NUM_MB - 1;
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [NUM_MB-1:0] TAIL_BIT = NUM_MB'(1) << TAIL;

  logic [NUM_MB-1:0] full_q, lost_q, full_d, lost_d, clr, grant;
  logic [IDX_W-1:0]  idx, wr_idx;
  logic              any_free, ovr_take, cap, ovr, wr_en, drop;
  logic [CNT_W-1:0]  drop_q;

  rxmb_pick #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_pick (
    .full(full_q), .tail_mode(tail_mode), .grant(grant), .idx(idx),
    .any_free(any_free), .ovr_take(ovr_take)
  );

  assign cap    = frame_valid && any_free;
  assign ovr    = frame_valid && ovr_take;
  assign drop   = frame_valid && !any_free && !ovr_take;
  assign wr_en  = cap || ovr;
  assign wr_idx = cap ? idx : IDX_W'(TAIL);
  assign clr    = rearm_we ? rearm_mask : '0;

  always_comb begin
    full_d = (full_q & ~clr) | (cap ? grant : '0) | (ovr ? TAIL_BIT : '0);
    lost_d = (lost_q & ~clr) | (ovr ? TAIL_BIT : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= '0;
      lost_q <= '0;
      drop_q <= '0;
      irq    <= 1'b0;
    end else begin
      full_q <= full_d;
      lost_q <= lost_d;
      irq    <= |(full_d & irq_en);
      if (drop && drop_q != CNT_MAX) drop_q <= drop_q + 1'b1;
    end
  end

  rxmb_store #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_idx),
    .wid(pack_id(frame_ide, frame_id)),
    .wmeta('{rtr: frame_rtr, dlc: frame_dlc}),
    .wdata(frame_data), .full(full_q), .lost(lost_q),
    .rd_mb(rd_mb), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  assign ready_map  = full_q;
  assign drop_count = drop_q;

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));

  // R5
  lost_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lost_q[TAIL]) |-> ($past(frame_valid) && $past(full_q[TAIL])));

  // R6
  drop_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (drop && drop_q != CNT_MAX) |=> (drop_q == $past(drop_q) + 1'b1));

  // R6
  drop_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (drop_q == CNT_MAX) |=> (drop_q == CNT_MAX));

  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb_chk
    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (full_q[g] && !(rearm_we && rearm_mask[g])) |=> full_q[g]);
    // R4
    rearm_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (rearm_we && rearm_mask[g] && !(wr_en && int'(wr_idx) == g)) |=> !full_q[g]);
  end
endmodule

// File: tb/rx_mbox_bank_tb.sv
`timescale 1ns/1ps
module rx_mbox_bank_tb;
  localparam int N = 12;
  localparam int T = N - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, frame_valid, frame_ide, frame_rtr, rearm_we, irq;
  logic [28:0] frame_id;
  logic [3:0]  frame_dlc, rd_mb;
  logic [63:0] frame_data;
  logic [1:0]  tail_mode, rd_sel;
  logic [N-1:0] rearm_mask, irq_en, ready_map;
  logic [31:0] rd_data;
  logic [7:0]  drop_count;

  rx_mbox_bank u_dut (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_ide(frame_ide),
    .frame_rtr(frame_rtr), .frame_id(frame_id), .frame_dlc(frame_dlc),
    .frame_data(frame_data), .tail_mode(tail_mode), .rearm_we(rearm_we),
    .rearm_mask(rearm_mask), .irq_en(irq_en), .rd_mb(rd_mb), .rd_sel(rd_sel),
    .rd_data(rd_data), .ready_map(ready_map), .irq(irq), .drop_count(drop_count)
  );

  int tests = 0, fails = 0;

  logic [N-1:0] m_full, m_lost, m_wr;
  logic [31:0]  m_id [N];
  logic [3:0]   m_dlc[N];
  logic         m_rtr[N];
  logic [63:0]  m_dat[N];
  int           m_drop;

  function automatic logic [31:0] exp_id(input logic ide, input logic [28:0] id);
    return ide ? {3'b001, id} : {3'b000, id[10:0], 18'd0};
  endfunction

  function automatic logic [31:0] exp_read(input int mb, input int sel);
    if (mb >= N) return 32'd0;
    case (sel)
      0: return m_id[mb];
      1: return {7'd0, m_lost[mb], m_full[mb], 2'd0, m_rtr[mb], m_dlc[mb], 16'd0};
      2: return m_dat[mb][31:0];
      default: return m_dat[mb][63:32];
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic fv, input logic ide, input logic rtr, input logic [28:0] id,
                      input logic [3:0] dlc, input logic rw, input logic [N-1:0] rm,
                      input int rmb, input int rsel, input string tag);
    logic [63:0]  dat;
    logic [31:0]  exp_rd;
    logic         rd_chk;
    logic [N-1:0] free, clr, setb, ovrb;
    int           k;
    dat = {$urandom, $urandom};
    frame_valid = fv; frame_ide = ide; frame_rtr = rtr; frame_id = id;
    frame_dlc = dlc; frame_data = dat; rearm_we = rw; rearm_mask = rm;
    rd_mb = 4'(rmb); rd_sel = 2'(rsel);
    exp_rd = exp_read(rmb, rsel);
    rd_chk = (rmb >= N) || m_wr[rmb];
    free = ~m_full;
    if (!(tail_mode == 2'd1 || tail_mode == 2'd2)) free[T] = 1'b0;
    clr = rw ? rm : '0;
    setb = '0; ovrb = '0; k = -1;
    if (fv) begin
      for (int i = N - 1; i >= 0; i--) if (free[i]) k = i;
      if (k < 0 && tail_mode == 2'd2) begin k = T; ovrb[T] = 1'b1; end
      if (k >= 0) begin
        setb[k] = 1'b1; m_wr[k] = 1'b1;
        m_id[k] = exp_id(ide, id); m_dlc[k] = dlc; m_rtr[k] = rtr; m_dat[k] = dat;
      end else if (m_drop < 255) m_drop++;
    end
    m_full = (m_full & ~clr) | setb;
    m_lost = (m_lost & ~clr) | ovrb;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "ready_map", 64'(ready_map), 64'(m_full));
    if (rd_chk) chk(tag, "rd_data", 64'(rd_data), 64'(exp_rd));
    chk("R6", "drop_count", 64'(drop_count), 64'(m_drop));
    chk("R10", "irq", 64'(irq), 64'(|(m_full & irq_en)));
  endtask

  task automatic frm(input logic ide, input logic [28:0] id, input string tag);
    step(1'b1, ide, 1'b0, id, 4'(($urandom % 9)), 1'b0, '0, 0, 1, tag);
  endtask

  task automatic idle_rd(input int mb, input int sel, input string tag);
    step(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, '0, mb, sel, tag);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2718);
    m_full = '0; m_lost = '0; m_wr = '0; m_drop = 0;
    rst = 1'b1; frame_valid = 0; frame_ide = 0; frame_rtr = 0; frame_id = '0;
    frame_dlc = '0; frame_data = '0; tail_mode = 2'd2; rearm_we = 0;
    rearm_mask = '0; irq_en = '1; rd_mb = '0; rd_sel = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "ready_map", 64'(ready_map), 0);
    chk("R1", "irq", 64'(irq), 0);
    chk("R1", "drop_count", 64'(drop_count), 0);
    chk("R1", "rd_data", 64'(rd_data), 0);
    rst = 1'b0;
    // R2 first frame to mailbox 0
    step(1'b1, 1'b0, 1'b0, 29'h123, 4'd8, 1'b0, '0, 0, 1, "R2");
    // R8 extended identifier, read standard packing of mb0
    step(1'b1, 1'b1, 1'b1, 29'h1ABCDE12, 4'd3, 1'b0, '0, 0, 0, "R8");
    idle_rd(1, 0, "R8");
    idle_rd(1, 1, "R9");
    idle_rd(0, 1, "R9");
    idle_rd(0, 2, "R12");
    idle_rd(0, 3, "R12");
    idle_rd(13, 0, "R12");
    // R3 full slots are skipped
    for (int i = 0; i < 9; i++) frm(1'b0, 29'(i * 7 + 1), "R3");
    frm(1'b1, 29'h0F00F00, "R2");
    // R5 overwrite of a full bank
    frm(1'b0, 29'h7FF, "R5");
    idle_rd(T, 1, "R5");
    idle_rd(T, 0, "R5");
    // R4 re-arm subset; R7 lost cleared
    step(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, 12'h821, 0, 0, "R4");
    idle_rd(T, 1, "R7");
    // R11 frame and re-arm of a lower slot in the same cycle
    step(1'b1, 1'b0, 1'b0, 29'h055, 4'd2, 1'b1, 12'h002, 0, 0, "R11");
    frm(1'b0, 29'h056, "R11");
    frm(1'b0, 29'h057, "R11");
    frm(1'b0, 29'h058, "R11");
    // R11 overwrite and re-arm of the last slot in the same cycle
    step(1'b1, 1'b0, 1'b1, 29'h3AA, 4'd5, 1'b1, 12'h804, 0, 0, "R11");
    idle_rd(T, 1, "R11");
    // R10 masked interrupt
    irq_en = 12'h008;
    step(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, '1, 0, 0, "R10");
    for (int i = 0; i < 4; i++) frm(1'b0, 29'(i), "R10");
    // R6 last slot disabled: drops, no change, saturation
    tail_mode = 2'd0; irq_en = '1;
    step(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, '1, 0, 0, "R6");
    for (int i = 0; i < T; i++) frm(1'b0, 29'(i), "R6");
    for (int i = 0; i < 260; i++) frm(1'b1, 29'(i), "R6");
    idle_rd(T - 1, 0, "R6");
    // R6 last slot as ordinary receive
    tail_mode = 2'd1;
    step(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, '1, 0, 0, "R6");
    for (int i = 0; i < N + 2; i++) frm(1'b0, 29'(i), "R6");
    idle_rd(T, 1, "R6");
    // R11 random mix of frames, re-arms and reads
    for (int c = 0; c < 6; c++) begin
      tail_mode = 2'($urandom % 4);
      irq_en = N'($urandom);
      for (int s = 0; s < 500; s++)
        step(($urandom % 2) == 0, 1'($urandom), 1'($urandom), 29'($urandom), 4'($urandom % 9),
             ($urandom % 4) == 0, N'($urandom), int'($urandom % 14), int'($urandom % 4), "R11");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule